// File: doc/BRIEF.md
# Block-State Parallel IIR Filter

This block runs an order-N recursive filter at P samples per clock. The filter is kept in state-space form. Each cycle it takes a vector of P consecutive input samples and returns the P matching output samples. An N-element state vector leaps P sample steps in a single update, using a precomputed power of the transition matrix. The output lanes are formed from that state and from the current input vector through a causal, lower-triangular feed-through map. All block matrices are fixed-point build parameters computed off-chip. The block has no coefficient loading port.

Samples move on valid/ready streams. A block is transferred on a cycle in which valid and ready are both high. The source must hold its data stable while valid is high and ready is low. A build option, `OUT_MODE`, selects between two output paths:

- Direct mode: the output vector is a combinational function of the state register and the presented input. Back-pressure passes straight from the output to the input.
- Registered mode: adds a one-deep stage that captures the pre-update state and the input vector. The output then comes only from registers, one cycle after acceptance. This stage accepts a new block when it is empty or is being drained in the same cycle.

Top module: `blkiir_filter`

## Requirements
- R1: For each accepted block, the state moves from x to A_BLK·x + B_BLK·u, rounded half-up to STATE_FRAC fraction bits. A stream of blocks therefore tracks the one-sample recursion x(n+1) = A x(n) + b u(n), y(n) = c·x(n) + d u(n).
- R2: Lane i of the output equals row i of C_BLK·x plus the sum over j ≤ i of D_TAP[i−j]·u_j. Input lane j sits at bits [j*DATA_W +: DATA_W], and lane 0 is the oldest sample. An input in a later lane never changes an earlier output lane.
- R3: The state changes only in a cycle with in_valid and in_ready both high. A block held under back-pressure advances the state exactly once.
- R4: In direct mode, out_valid follows in_valid and in_ready follows out_ready, and the output is formed in the same cycle as the input.
- R5: In registered mode, a block reaches the output in the cycle after it is accepted, and never earlier. It stays valid and stable while out_ready is low. in_ready is high whenever the stage is empty or out_ready is high.
- R6: Each output is rounded once, as floor(y + 0.5). An exact +0.5 gives 1 and an exact −0.5 gives 0.
- R7: Outputs beyond the OUT_W signed range saturate to the nearest limit.
- R8: The active-low asynchronous reset clears the state and empties the registered stage, so a zero block after reset yields zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can be taken this cycle |
| in_data | input | P*DATA_W | P signed input samples, lane 0 oldest in the low bits |
| out_valid | output | 1 | Output block present |
| out_ready | input | 1 | Sink takes the output block |
| out_data | output | P*OUT_W | P signed output samples, lane 0 in the low bits |

## Verification
The bench runs a sample-by-sample real-valued recursion on the same stream and compares every lane. It requires exact results whenever the state starts from zero.

- Exact ±0.5 outputs separate half-up rounding from truncation or round-away; either error would move a lane by one.
- An impulse in the last lane exposes a feed-through map with a wrong triangle or a wrong lane order, since earlier lanes would turn non-zero.
- Blocks held under random and long stalls expose a state that advances per cycle rather than per transfer; every later block would then drift from the reference.
- Full-scale input runs expose wrap-around instead of saturation.
- In registered mode, the bench checks that nothing appears before the first load and that the held output stays frozen under stall.

// File: rtl/blkiir_pkg.sv
package blkiir_pkg;

  localparam int unsigned DEF_COEF_W    = 18;
  localparam int unsigned DEF_COEF_FRAC = 14;

  // Output path selection: combinational from live state, or from a register stage.
  typedef enum logic {
    OUT_DIRECT     = 1'b0,
    OUT_REGISTERED = 1'b1
  } out_mode_e;

endpackage

// File: rtl/blkiir_round_sat.sv
module blkiir_round_sat #(
  parameter int IW = 48,
  parameter int SH = 14,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] acc_i,
  output logic signed [OW-1:0] val_o
);

  localparam logic signed [IW-1:0] HALF = IW'(64'sd1 <<< (SH - 1));
  localparam logic signed [IW-1:0] MAXV = IW'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [IW-1:0] MINV = -MAXV - IW'(64'sd1);

  logic signed [IW-1:0] rnd;
  logic signed [IW-1:0] shf;

  always_comb begin
    rnd = acc_i + HALF;
    shf = rnd >>> SH;
    if (shf > MAXV)      val_o = MAXV[OW-1:0];
    else if (shf < MINV) val_o = MINV[OW-1:0];
    else                 val_o = shf[OW-1:0];
  end

endmodule

// File: rtl/blkiir_state_upd.sv
module blkiir_state_upd #(
  parameter int N  = 2,
  parameter int P  = 4,
  parameter int DW = 16,
  parameter int SW = 40,
  parameter int SF = 14,
  parameter int CW = 18,
  parameter int CF = 14,
  parameter int AW = 63,
  parameter logic [N*N*CW-1:0] A_BLK = '0,
  parameter logic [N*P*CW-1:0] B_BLK = '0
) (
  input  logic [N*SW-1:0] x_i,
  input  logic [P*DW-1:0] u_i,
  output logic [N*SW-1:0] x_o
);

  for (genvar r = 0; r < N; r++) begin : g_row
    logic signed [AW-1:0] acc;
    logic signed [SW-1:0] nxt;

    always_comb begin
      acc = '0;
      for (int k = 0; k < N; k++) begin
        acc = acc + AW'($signed(A_BLK[(r*N + k)*CW +: CW])) * AW'($signed(x_i[k*SW +: SW]));
      end
      for (int j = 0; j < P; j++) begin
        acc = acc + AW'($signed(B_BLK[(r*P + j)*CW +: CW]))
                    * (AW'($signed(u_i[j*DW +: DW])) <<< SF);
      end
    end

    blkiir_round_sat #(.IW(AW), .SH(CF), .OW(SW)) u_rs (
      .acc_i (acc),
      .val_o (nxt)
    );

    assign x_o[r*SW +: SW] = nxt;
  end

endmodule

// File: rtl/blkiir_out_map.sv
module blkiir_out_map #(
  parameter int N  = 2,
  parameter int P  = 4,
  parameter int DW = 16,
  parameter int SW = 40,
  parameter int SF = 14,
  parameter int CW = 18,
  parameter int CF = 14,
  parameter int OW = 16,
  parameter int AW = 63,
  parameter logic [P*N*CW-1:0] C_BLK = '0,
  parameter logic [P*CW-1:0]   D_TAP = '0
) (
  input  logic [N*SW-1:0] x_i,
  input  logic [P*DW-1:0] u_i,
  output logic [P*OW-1:0] y_o
);

  for (genvar i = 0; i < P; i++) begin : g_lane
    logic signed [AW-1:0] acc;
    logic signed [OW-1:0] yl;

    always_comb begin
      acc = '0;
      for (int k = 0; k < N; k++) begin
        acc = acc + AW'($signed(C_BLK[(i*N + k)*CW +: CW])) * AW'($signed(x_i[k*SW +: SW]));
      end
      // Only the causal part j <= i is built; the upper triangle costs nothing.
      for (int j = 0; j <= i; j++) begin
        acc = acc + AW'($signed(D_TAP[(i - j)*CW +: CW]))
                    * (AW'($signed(u_i[j*DW +: DW])) <<< SF);
      end
    end

    blkiir_round_sat #(.IW(AW), .SH(CF + SF), .OW(OW)) u_rs (
      .acc_i (acc),
      .val_o (yl)
    );

    assign y_o[i*OW +: OW] = yl;
  end

endmodule

// File: rtl/blkiir_filter.sv
module blkiir_filter
  import blkiir_pkg::*;
#(
  parameter int        N          = 2,
  parameter int        P          = 4,
  parameter int        DATA_W     = 16,
  parameter int        COEF_W     = DEF_COEF_W,
  parameter int        COEF_FRAC  = DEF_COEF_FRAC,
  parameter int        STATE_W    = 40,
  parameter int        STATE_FRAC = 14,
  parameter int        OUT_W      = 16,
  parameter out_mode_e OUT_MODE   = OUT_DIRECT,
  // Transition matrix raised to the P-th power, entry (r,k) at index r*N+k.
  parameter logic [N*N*COEF_W-1:0] A_BLK = {18'sd0, -18'sd2048, 18'sd512, -18'sd1024},
  // Input-to-state map, entry (r,j) at index r*P+j.
  parameter logic [N*P*COEF_W-1:0] B_BLK = {18'sd0, 18'sd16384, 18'sd8192, 18'sd0,
                                            18'sd16384, 18'sd8192, 18'sd0, -18'sd2048},
  // State-to-output map, entry (i,k) at index i*N+k.
  parameter logic [P*N*COEF_W-1:0] C_BLK = {-18'sd384, -18'sd1280, -18'sd2048, 18'sd1536,
                                            -18'sd2560, 18'sd8192, 18'sd3072, 18'sd10240},
  // Feed-through taps by lane distance i-j; tap 0 is the direct term.
  parameter logic [P*COEF_W-1:0]   D_TAP = {18'sd1536, 18'sd8192, 18'sd10240, 18'sd4096}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [P*DATA_W-1:0]   in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [P*OUT_W-1:0]    out_data
);

  localparam int GUARD_W = $clog2(N + P) + 2;
  localparam int ACC_W   = COEF_W + STATE_W + GUARD_W;

  logic [N*STATE_W-1:0] x_q;
  logic [N*STATE_W-1:0] x_nxt;
  logic [N*STATE_W-1:0] map_x;
  logic [P*DATA_W-1:0]  map_u;
  logic                 accept;

  blkiir_state_upd #(
    .N(N), .P(P), .DW(DATA_W), .SW(STATE_W), .SF(STATE_FRAC),
    .CW(COEF_W), .CF(COEF_FRAC), .AW(ACC_W), .A_BLK(A_BLK), .B_BLK(B_BLK)
  ) u_upd (
    .x_i (x_q),
    .u_i (in_data),
    .x_o (x_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      x_q <= '0;
    else if (accept) x_q <= x_nxt;
  end

  if (OUT_MODE == OUT_DIRECT) begin : g_direct
    assign accept    = in_valid && out_ready;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign map_x     = x_q;
    assign map_u     = in_data;
  end else begin : g_registered
    logic [N*STATE_W-1:0] hold_x;
    logic [P*DATA_W-1:0]  hold_u;
    logic                 hold_v;

    assign in_ready  = !hold_v || out_ready;
    assign accept    = in_valid && in_ready;
    assign out_valid = hold_v;
    assign map_x     = hold_x;
    assign map_u     = hold_u;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_v <= 1'b0;
        hold_x <= '0;
        hold_u <= '0;
      end else if (accept) begin
        hold_v <= 1'b1;
        hold_x <= x_q;
        hold_u <= in_data;
      end else if (out_ready) begin
        hold_v <= 1'b0;
      end
    end
  end

  blkiir_out_map #(
    .N(N), .P(P), .DW(DATA_W), .SW(STATE_W), .SF(STATE_FRAC),
    .CW(COEF_W), .CF(COEF_FRAC), .OW(OUT_W), .AW(ACC_W), .C_BLK(C_BLK), .D_TAP(D_TAP)
  ) u_map (
    .x_i (map_x),
    .u_i (map_u),
    .y_o (out_data)
  );

endmodule

// File: rtl/blkiir_filter_chk.sv
module blkiir_filter_chk
  import blkiir_pkg::*;
#(
  parameter int        N        = 2,
  parameter int        P        = 4,
  parameter int        STATE_W  = 40,
  parameter int        OUT_W    = 16,
  parameter out_mode_e OUT_MODE = OUT_DIRECT
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [P*OUT_W-1:0]   out_data,
  input logic [N*STATE_W-1:0] x_q
);

  // R3
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(x_q));

  // R2
  out_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_data));

  if (OUT_MODE == OUT_DIRECT) begin : g_direct_chk
    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && out_ready |-> out_valid && in_ready);

    // R4
    backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);
  end else begin : g_reg_chk
    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R5
    empty_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

    // R5
    load_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
  end

endmodule

bind blkiir_filter blkiir_filter_chk #(
  .N(N), .P(P), .STATE_W(STATE_W), .OUT_W(OUT_W), .OUT_MODE(OUT_MODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .x_q       (x_q)
);

// File: tb/blkiir_filter_bench.sv
module blkiir_filter_bench;
  import blkiir_pkg::*;

  localparam int P  = 4;
  localparam int DW = 16;

  typedef struct packed {
    logic [2:0]      tag;
    logic [1:0]      tol;
    logic [P*DW-1:0] y;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            iv[2];
  logic            ir[2];
  logic            ov[2];
  logic            ordy[2];
  logic [P*DW-1:0] idat[2];
  logic [P*DW-1:0] odat[2];

  blkiir_filter u_blkiir_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(ir[0]), .in_data(idat[0]),
    .out_valid(ov[0]), .out_ready(ordy[0]), .out_data(odat[0])
  );

  blkiir_filter #(.OUT_MODE(OUT_REGISTERED)) u_blkiir_filter_reg (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(ir[1]), .in_data(idat[1]),
    .out_valid(ov[1]), .out_ready(ordy[1]), .out_data(odat[1])
  );

  int   checks = 0;
  int   errors = 0;
  bit   fresh[2];
  int   rdy_mode[2];
  real  rx[2][2];
  exp_t sbq[2][$];
  bit   finished = 0;

  function automatic string tag_name(logic [2:0] t);
    case (t)
      3'd1:    return "R1";
      3'd2:    return "R2";
      3'd3:    return "R3";
      3'd6:    return "R6";
      3'd7:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [P*DW-1:0] mk(int a, int b, int c, int d);
    return {16'(d), 16'(c), 16'(b), 16'(a)};
  endfunction

  // Sample-serial reference: x' = A x + b u, y = c.x + d u, then floor(y+0.5) and clamp.
  task automatic ref_block(int w, logic [P*DW-1:0] blk, output logic [P*DW-1:0] yv);
    for (int j = 0; j < P; j++) begin
      real u, y, n0;
      int  q;
      u  = real'($signed(blk[j*DW +: DW]));
      y  = 0.625 * rx[w][0] + 0.1875 * rx[w][1] + 0.25 * u;
      n0 = 0.5 * rx[w][0] - 0.25 * rx[w][1] + u;
      rx[w][1] = rx[w][0];
      rx[w][0] = n0;
      q = $rtoi($floor(y + 0.5));
      if (q > 32767)  q = 32767;
      if (q < -32768) q = -32768;
      yv[j*DW +: DW] = 16'(q);
    end
  endtask

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic send(int w, logic [P*DW-1:0] blk, logic [2:0] tag);
    exp_t e;
    logic [P*DW-1:0] yv;
    bit ok;
    bit first;
    ref_block(w, blk, yv);
    e.tag = tag;
    e.tol = fresh[w] ? 2'd0 : 2'd1;
    e.y   = yv;
    first = fresh[w] && (w == 1);
    fresh[w] = 1'b0;
    iv[w]   = 1'b1;
    idat[w] = blk;
    sbq[w].push_back(e);
    do begin
      @(negedge clk);
      if (first) begin
        // R5: nothing on the registered output before the first load
        chk(ov[1] == 1'b0, "R5", "output valid before first load", ov[1], 0);
        first = 0;
      end
      ok = ir[w];
      if (!ok) begin @(posedge clk); #1; end
    end while (!ok);
    @(posedge clk); #1;
    iv[w] = 1'b0;
  endtask

  task automatic do_reset();
    rdy_mode[0] = 0;
    rdy_mode[1] = 0;
    while (sbq[0].size() != 0 || sbq[1].size() != 0) @(posedge clk);
    @(posedge clk); #1;
    rst_n = 1'b0;
    for (int w = 0; w < 2; w++) begin
      iv[w] = 1'b0; fresh[w] = 1'b1; rx[w][0] = 0.0; rx[w][1] = 0.0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R8
    chk(ov[1] == 1'b0, "R8", "registered stage empty in reset", ov[1], 0);
    chk(ir[1] == 1'b1, "R8", "registered stage ready in reset", ir[1], 1);
    chk(ov[0] == 1'b0, "R8", "direct output idle in reset", ov[0], 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  // Sink ready pattern, changed away from both clock edges.
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    ordy[0] = 1'b1; ordy[1] = 1'b1;
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int w = 0; w < 2; w++) begin
        case (rdy_mode[w])
          0:       ordy[w] = 1'b1;
          1:       ordy[w] = lfsr[w*3];
          default: ordy[w] = 1'b0;
        endcase
      end
    end
  end

  // Scoreboard monitor plus handshake rules.
  initial begin
    bit              prev_stall = 0;
    logic [P*DW-1:0] prev_dat = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        for (int w = 0; w < 2; w++) begin
          if (ov[w] && ordy[w]) begin
            if (sbq[w].size() == 0) begin
              chk(1'b0, "R2", "unexpected output block", 1, 0);
            end else begin
              exp_t e;
              e = sbq[w].pop_front();
              for (int j = 0; j < P; j++) begin
                longint a, x;
                a = longint'($signed(odat[w][j*DW +: DW]));
                x = longint'($signed(e.y[j*DW +: DW]));
                chk((a - x <= longint'(e.tol)) && (x - a <= longint'(e.tol)),
                    tag_name(e.tag), $sformatf("dut%0d lane%0d", w, j), a, x);
              end
            end
          end
        end
        // R4: direct-mode valid and ready pass straight through
        chk(ov[0] == iv[0] && ir[0] == ordy[0], "R4", "direct handshake",
            {ov[0], ir[0]}, {iv[0], ordy[0]});
        // R5: held output stays frozen; ready when empty or draining
        if (prev_stall)
          chk(ov[1] && odat[1] == prev_dat, "R5", "stalled output hold", ov[1], 1);
        chk(ir[1] == (!ov[1] || ordy[1]), "R5", "registered ready rule", ir[1], !ov[1] || ordy[1]);
        prev_stall = ov[1] && !ordy[1];
        prev_dat   = odat[1];
      end else begin
        prev_stall = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R3", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    for (int w = 0; w < 2; w++) begin
      iv[w] = 1'b0; idat[w] = '0; rdy_mode[w] = 0;
    end
    do_reset();
    for (int w = 0; w < 2; w++) begin
      // R6: exact +0.5 and -0.5 outputs from zero state
      send(w, mk(2, 0, 0, 0), 3'd6);
      do_reset();
      send(w, mk(-2, 0, 0, 0), 3'd6);
      do_reset();
      // R2: last-lane impulse must leave lanes 0..2 at zero
      send(w, mk(0, 0, 0, 3000), 3'd2);
      send(w, mk(0, 0, 0, 0), 3'd2);
      do_reset();
      // R1: state carried across blocks
      send(w, mk(1000, 0, 0, 0), 3'd1);
      for (int k = 0; k < 5; k++) send(w, mk(0, 0, 0, 0), 3'd1);
      send(w, mk(-700, 1200, 300, -2500), 3'd1);
      send(w, mk(4000, 4000, -4000, -4000), 3'd1);
      // R3: long stall on one block, then random back-pressure
      rdy_mode[w] = 2;
      fork
        send(w, mk(1500, -900, 2200, 50), 3'd3);
        begin repeat (6) @(posedge clk); #3; rdy_mode[w] = 0; end
      join
      rdy_mode[w] = 1;
      for (int k = 0; k < 40; k++) begin
        send(w, mk($urandom_range(16000) - 8000, $urandom_range(16000) - 8000,
                   $urandom_range(16000) - 8000, $urandom_range(16000) - 8000), 3'd3);
        if (k % 7 == 3) begin @(posedge clk); #1; end
      end
      rdy_mode[w] = 0;
      // R7: full-scale runs must clamp
      for (int k = 0; k < 10; k++) send(w, mk(32767, 32767, 32767, 32767), 3'd7);
      for (int k = 0; k < 10; k++) send(w, mk(-32768, -32768, -32768, -32768), 3'd7);
      // R8: reset clears accumulated state
      do_reset();
      send(w, mk(0, 0, 0, 0), 3'd0);
      do_reset();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule